// File: doc/BRIEF.md
# Machine-Mode Performance Counter Unit

This block holds the hardware performance counters that sit next to a machine-mode CSR file. It always provides a 64-bit cycle counter and a 64-bit retired-instruction counter. It also provides a build-time number of 64-bit event counters, and each event counter has its own one-hot event selector. A count-inhibit register starts or stops every implemented counter on its own.

Software reaches the block through a simple CSR port: a 12-bit address, a write enable, an operation code (write, set bits, clear bits) and 32-bit write data. Read data is combinational from the address. The surrounding core supplies a 16-bit vector with one pulse per cycle for each monitorable event. Each 64-bit counter appears as a low 32-bit half and a high 32-bit half.

Top module: `perfCounters`

## Requirements
- R1: The cycle counter (slot 0) adds one on every clock edge at which its inhibit bit is clear. The low half carries into the high half in the same cycle, so the 64-bit value is continuous.
- R2: The retired-instruction counter (slot 2) adds one on each edge where `events[1]` is high and inhibit bit 2 is clear.
- R3: Event counter X (slots 3 up to 3+NUM_EVT-1) adds one on each edge where the event picked by the single set bit of its 16-bit selector is high and inhibit bit X is clear. A selector of zero counts nothing. Event bit positions: 0 cycle, 1 retired instruction, 2 compressed retired, 3 unconditional jump, 4 conditional branch, 5 taken branch, 6 interrupt taken (no NMI), 7 data read, 8 data write, 9..12 IF/ID/EX/WB underutilization, 13 load-use stall, 14 jump-register stall, 15 WB data stall.
- R4: After reset all counters and selectors read 0. The inhibit register reads 1 in every implemented slot, which is 0x0000000D for the default NUM_EVT=1.
- R5: The inhibit register sits at 0x320, and bit X controls slot X. Bit 1 and the bits of absent slots always read 0 and cannot be set.
- R6: Selectors sit at 0x320+X. Counter low halves sit at 0xB00+X and high halves at 0xB80+X.
- R7: `csrOp` 0 writes the addressed 32-bit register, 1 ORs the write data into it, and 2 clears the bits set in the write data. Code 3 changes nothing. Only the addressed half of a counter is touched.
- R8: A write to a counter half wins over that cycle's increment. The other half keeps its value.
- R9: Addresses of absent slots (counter slot 1, selectors 0x321/0x322, slots beyond the parameter) and all unmapped addresses read 0. Writes to them change no state.
- R10: Reads never change any counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csrAddr | input | 12 | CSR address |
| csrWe | input | 1 | Write strobe |
| csrOp | input | 2 | 0 write, 1 set bits, 2 clear bits, 3 none |
| csrWdata | input | 32 | Write data |
| events | input | 16 | One pulse per cycle per event |
| csrRdata | output | 32 | Read data for csrAddr |

## Verification
The bench targets the carry from 0xFFFFFFFE across the half boundary. A design that drops the carry would show a high half that stays put while the low half wraps. It also writes a counter while that counter is running, so a design that lets the increment win would read back one more than the written value. A table of selector and event patterns checks that only the selected bit counts and that a zero selector stays silent; a wrong select mux counts unrelated events. Writes with all ones to the inhibit register, and writes to absent slots, expose bits that should be hardwired to zero and state that should be ignored.

// File: rtl/perfPkg.sv
package perfPkg;
  localparam int unsigned EVENT_COUNT = 16;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned CNT_W       = 2 * WORD_W;
  localparam int unsigned SLOT_COUNT  = 32;
  localparam int unsigned FIRST_EVT   = 3;
  localparam int unsigned RETIRED_BIT = 1;

  localparam logic [11:0] INHIBIT_ADDR = 12'h320;
  localparam logic [11:0] CNT_LO_BASE  = 12'hB00;
  localparam logic [11:0] CNT_HI_BASE  = 12'hB80;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } csrOp_e;

  typedef struct packed {
    logic              wrInhibit;
    logic              wrSel;
    logic              wrLo;
    logic              wrHi;
    logic [4:0]        slot;
    logic [WORD_W-1:0] value;
  } wrStrobe_t;

  function automatic logic slotPresent(input logic [4:0] slot, input int unsigned numEvt);
    int unsigned s;
    s = 32'(slot);
    return (s == 0) || (s == 2) || ((s >= FIRST_EVT) && (s < FIRST_EVT + numEvt));
  endfunction

  function automatic logic [SLOT_COUNT-1:0] presentMask(input int unsigned numEvt);
    logic [SLOT_COUNT-1:0] m;
    for (int i = 0; i < SLOT_COUNT; i++) m[i] = slotPresent(5'(i), numEvt);
    return m;
  endfunction
endpackage

// File: rtl/perfCtrl.sv
module perfCtrl
  import perfPkg::*;
#(
  parameter int unsigned NUM_EVT = 1
) (
  input  logic [11:0]       csrAddr,
  input  logic              csrWe,
  input  logic [1:0]        csrOp,
  input  logic [WORD_W-1:0] csrWdata,
  input  logic [WORD_W-1:0] curData,
  output wrStrobe_t         strobe
);
  localparam logic [6:0] SEL_BLOCK = INHIBIT_ADDR[11:5];
  localparam logic [6:0] LO_BLOCK  = CNT_LO_BASE[11:5];
  localparam logic [6:0] HI_BLOCK  = CNT_HI_BASE[11:5];

  logic [4:0] slot;
  logic       opValid;
  logic       present;
  logic [6:0] block;

  always_comb begin
    slot    = csrAddr[4:0];
    block   = csrAddr[11:5];
    opValid = csrWe && (csrOp != OP_NONE);
    present = slotPresent(slot, NUM_EVT);

    strobe.slot = slot;
    unique case (csrOp)
      OP_WRITE: strobe.value = csrWdata;
      OP_SET:   strobe.value = curData | csrWdata;
      OP_CLEAR: strobe.value = curData & ~csrWdata;
      default:  strobe.value = curData;
    endcase

    strobe.wrInhibit = opValid && (block == SEL_BLOCK) && (slot == 5'd0);
    strobe.wrSel     = opValid && (block == SEL_BLOCK) && (slot >= 5'(FIRST_EVT)) && present;
    strobe.wrLo      = opValid && (block == LO_BLOCK) && present;
    strobe.wrHi      = opValid && (block == HI_BLOCK) && present;
  end
endmodule

// File: rtl/perfDatapath.sv
module perfDatapath
  import perfPkg::*;
#(
  parameter int unsigned NUM_EVT = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [EVENT_COUNT-1:0] events,
  input  wrStrobe_t              strobe,
  input  logic [11:0]            csrAddr,
  output logic [WORD_W-1:0]      csrRdata,
  output logic [CNT_W-1:0]       cntAll [SLOT_COUNT],
  output logic [SLOT_COUNT-1:0]  inhibitVal
);
  localparam logic [SLOT_COUNT-1:0] INH_MASK = presentMask(NUM_EVT);

  logic [EVENT_COUNT-1:0] selAll [SLOT_COUNT];
  logic [SLOT_COUNT-1:0]  inhibitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 inhibitQ <= INH_MASK;
    else if (strobe.wrInhibit) inhibitQ <= strobe.value & INH_MASK;
  end
  assign inhibitVal = inhibitQ;

  for (genvar g = 0; g < SLOT_COUNT; g++) begin : gSlot
    if (slotPresent(5'(g), NUM_EVT)) begin : gLive
      logic [CNT_W-1:0] cntQ;
      logic             hit;
      logic             wrHere;

      if (g == 0) begin : gCyc
        assign hit = 1'b1;
        assign selAll[g] = '0;
      end else if (g == 2) begin : gRet
        assign hit = events[RETIRED_BIT];
        assign selAll[g] = '0;
      end else begin : gEvt
        logic [EVENT_COUNT-1:0] selQ;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) selQ <= '0;
          else if (strobe.wrSel && strobe.slot == 5'(g)) selQ <= strobe.value[EVENT_COUNT-1:0];
        end
        assign hit = |(selQ & events);
        assign selAll[g] = selQ;
      end

      assign wrHere = strobe.slot == 5'(g);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                       cntQ <= '0;
        else if (strobe.wrLo && wrHere)  cntQ[WORD_W-1:0] <= strobe.value;
        else if (strobe.wrHi && wrHere)  cntQ[CNT_W-1:WORD_W] <= strobe.value;
        else if (!inhibitQ[g] && hit)    cntQ <= cntQ + CNT_W'(1);
      end
      assign cntAll[g] = cntQ;
    end else begin : gAbsent
      assign cntAll[g] = '0;
      assign selAll[g] = '0;
    end
  end

  always_comb begin
    csrRdata = '0;
    unique case (csrAddr[11:5])
      INHIBIT_ADDR[11:5]:
        csrRdata = (csrAddr[4:0] == 5'd0) ? inhibitQ : WORD_W'(selAll[csrAddr[4:0]]);
      CNT_LO_BASE[11:5]: csrRdata = cntAll[csrAddr[4:0]][WORD_W-1:0];
      CNT_HI_BASE[11:5]: csrRdata = cntAll[csrAddr[4:0]][CNT_W-1:WORD_W];
      default:           csrRdata = '0;
    endcase
  end
endmodule

// File: rtl/perfCounters.sv
module perfCounters
  import perfPkg::*;
#(
  parameter int unsigned NUM_EVT = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] csrAddr,
  input  logic        csrWe,
  input  logic [1:0]  csrOp,
  input  logic [31:0] csrWdata,
  input  logic [15:0] events,
  output logic [31:0] csrRdata
);
  wrStrobe_t             strobe;
  logic [CNT_W-1:0]      cntAll [SLOT_COUNT];
  logic [SLOT_COUNT-1:0] inhibitVal;

  perfCtrl #(.NUM_EVT(NUM_EVT)) uCtrl (
    .csrAddr (csrAddr),
    .csrWe   (csrWe),
    .csrOp   (csrOp),
    .csrWdata(csrWdata),
    .curData (csrRdata),
    .strobe  (strobe)
  );

  perfDatapath #(.NUM_EVT(NUM_EVT)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .events    (events),
    .strobe    (strobe),
    .csrAddr   (csrAddr),
    .csrRdata  (csrRdata),
    .cntAll    (cntAll),
    .inhibitVal(inhibitVal)
  );
endmodule

// File: rtl/perfCountersChk.sv
module perfCountersChk (
  input logic        clk,
  input logic        rstN,
  input logic [11:0] csrAddr,
  input logic        csrWe,
  input logic [1:0]  csrOp,
  input logic [31:0] csrWdata,
  input logic [31:0] csrRdata,
  input logic [15:0] events,
  input logic [63:0] cntAll [32],
  input logic [31:0] inhibitVal
);
  logic cycWr, retWr;
  assign cycWr = csrWe && (csrOp != 2'd3) && (csrAddr == 12'hB00 || csrAddr == 12'hB80);
  assign retWr = csrWe && (csrOp != 2'd3) && (csrAddr == 12'hB02 || csrAddr == 12'hB82);

  // R1
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inhibitVal[0] && !cycWr) |=> cntAll[0] == $past(cntAll[0]) + 64'd1);

  // R5
  cycle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inhibitVal[0] && !cycWr) |=> $stable(cntAll[0]));

  // R2
  retired_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inhibitVal[2] && events[1] && !retWr) |=> cntAll[2] == $past(cntAll[2]) + 64'd1);

  // R2
  retired_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!events[1] && !retWr) |=> $stable(cntAll[2]));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrOp == 2'd0 && csrAddr == 12'hB00) |=>
      (cntAll[0][31:0] == $past(csrWdata)) && (cntAll[0][63:32] == $past(cntAll[0][63:32])));

  // R9
  absent_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == 12'hB01 || csrAddr == 12'hB81 || csrAddr == 12'h321) |-> csrRdata == 32'd0);
endmodule

bind perfCounters perfCountersChk chk (.*);

// File: tb/perfCounters_test.sv
module perfCounters_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] csrAddr = '0;
  logic        csrWe = 1'b0;
  logic [1:0]  csrOp = 2'd0;
  logic [31:0] csrWdata = '0;
  logic [15:0] events = '0;
  logic [31:0] csrRdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  perfCounters uut (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrWe(csrWe),
    .csrOp(csrOp), .csrWdata(csrWdata), .events(events), .csrRdata(csrRdata)
  );

  always #4 clk = ~clk;

  // {selector, event pattern, expected count over a 4-edge window}
  localparam logic [39:0] VEC [7] = '{
    {16'h0001, 16'h0001, 8'd4},
    {16'h0020, 16'h0020, 8'd4},
    {16'h0020, 16'hFFDF, 8'd0},
    {16'h0000, 16'hFFFF, 8'd0},
    {16'h8000, 16'h8000, 8'd4},
    {16'h0200, 16'h0200, 8'd4},
    {16'h0004, 16'h0000, 8'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csrWrite(input logic [11:0] a, input logic [1:0] op, input logic [31:0] d);
    csrAddr = a; csrOp = op; csrWdata = d; csrWe = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic csrRead(input logic [11:0] a, output logic [31:0] d);
    csrAddr = a; csrWe = 1'b0;
    #1 d = csrRdata;
    @(negedge clk);
  endtask

  task automatic finish;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    logic [31:0] v, w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R4 reset state
    csrRead(12'h320, v); check("R4 inhibit reset", v, 32'h0000000D);
    csrRead(12'hB00, v); check("R4 cycle lo reset", v, 32'h0);
    csrRead(12'hB83, v); check("R4 event hi reset", v, 32'h0);
    csrRead(12'h323, v); check("R4 selector reset", v, 32'h0);

    // R3 table walk over event counter slot 3 (R6 addresses)
    for (int i = 0; i < 7; i++) begin
      csrWrite(12'h323, 2'd0, {16'h0, VEC[i][39:24]});
      csrWrite(12'hB03, 2'd0, 32'h0);
      events = VEC[i][23:8];
      csrWrite(12'h320, 2'd2, 32'h8);
      repeat (3) @(negedge clk);
      csrWrite(12'h320, 2'd1, 32'h8);
      events = '0;
      csrRead(12'hB03, v); check($sformatf("R3 vector %0d", i), v, {24'h0, VEC[i][7:0]});
      csrRead(12'hB03, w); check("R10 read is non-destructive", w, v);
    end
    csrRead(12'hB83, v); check("R6 event hi untouched", v, 32'h0);

    // R5 inhibit register masking
    csrWrite(12'h320, 2'd0, 32'hFFFFFFFF);
    csrRead(12'h320, v); check("R5 write all ones", v, 32'h0000000D);
    csrWrite(12'h320, 2'd2, 32'hFFFFFFFF);
    csrRead(12'h320, v); check("R5 clear all", v, 32'h0);
    csrWrite(12'h320, 2'd1, 32'hFFFFFFFF);
    csrRead(12'h320, v); check("R5 set all", v, 32'h0000000D);

    // R7 operations on a counter high half
    csrWrite(12'hB00, 2'd0, 32'h12345678);
    csrWrite(12'hB80, 2'd0, 32'h000000F0);
    csrWrite(12'hB80, 2'd1, 32'h0000000F);
    csrRead(12'hB80, v); check("R7 set bits", v, 32'h000000FF);
    csrWrite(12'hB80, 2'd2, 32'h00000033);
    csrRead(12'hB80, v); check("R7 clear bits", v, 32'h000000CC);
    csrWrite(12'hB80, 2'd3, 32'hFFFFFFFF);
    csrRead(12'hB80, v); check("R7 op 3 no change", v, 32'h000000CC);
    csrRead(12'hB00, v); check("R7 other half untouched", v, 32'h12345678);

    // R1 carry across halves
    csrWrite(12'hB00, 2'd0, 32'hFFFFFFFE);
    csrWrite(12'hB80, 2'd0, 32'h00000005);
    csrWrite(12'h320, 2'd2, 32'h1);
    repeat (2) @(negedge clk);
    csrWrite(12'h320, 2'd1, 32'h1);
    csrRead(12'hB00, v); check("R1 carry low", v, 32'h00000001);
    csrRead(12'hB80, v); check("R1 carry high", v, 32'h00000006);

    // R1 free-running step, R8 write beats increment
    csrWrite(12'h320, 2'd2, 32'h1);
    csrRead(12'hB00, v);
    csrRead(12'hB00, w); check("R1 step per cycle", w - v, 32'h1);
    csrWrite(12'hB00, 2'd0, 32'h00000100);
    csrRead(12'hB00, v); check("R8 written value wins", v, 32'h00000100);
    csrRead(12'hB80, v); check("R8 high kept", v, 32'h00000006);
    csrWrite(12'h320, 2'd1, 32'h1);

    // R2 retired-instruction pulses
    csrWrite(12'hB02, 2'd0, 32'h0);
    csrWrite(12'h320, 2'd2, 32'h4);
    events = 16'h0002; @(negedge clk);
    events = 16'h0000; @(negedge clk);
    events = 16'h0002; @(negedge clk);
    events = 16'h0000;
    csrWrite(12'h320, 2'd1, 32'h4);
    csrRead(12'hB02, v); check("R2 retired pulses", v, 32'h2);

    // R9 absent slots and unmapped space
    csrWrite(12'hB03, 2'd0, 32'h00000077);
    csrWrite(12'hB04, 2'd0, 32'h00000005);
    csrRead(12'hB04, v); check("R9 absent counter reads 0", v, 32'h0);
    csrRead(12'hB03, v); check("R9 neighbour unaffected", v, 32'h00000077);
    csrWrite(12'hB01, 2'd0, 32'h00000009);
    csrRead(12'hB01, v); check("R9 slot 1 reads 0", v, 32'h0);
    csrWrite(12'h324, 2'd0, 32'h00000001);
    csrRead(12'h324, v); check("R9 absent selector", v, 32'h0);
    csrRead(12'h322, v); check("R9 selector slot 2", v, 32'h0);
    csrRead(12'h7A0, v); check("R9 unmapped address", v, 32'h0);
    csrRead(12'hB02, v); check("R9 retired unaffected", v, 32'h2);

    finish();
  end
endmodule